// File: doc/BRIEF.md
# Guarded System Clock Prescaler

This block paces the synchronous logic of a chip by producing a clock-enable pulse at a power-of-two fraction of the input clock rate. A 4-bit select code picks the division, from 1 up to 256. The code sits in a single byte-wide register on a simple bus with a write strobe, write data and combinational read data. Every consumer that qualifies its registers with the enable slows down or speeds up together when the code changes.

A stray write must not alter the rate. So the code only changes through a two-step sequence. First an arming write sets the change-enable bit with every other bit zero. Then a second write, with the change-enable bit clear, carries the new code and must land within four cycles. A strap input chooses the value after reset. When the strap is inactive the prescaler comes up undivided. When it is active it comes up dividing by 8, for fast clock sources. Software can later write any legal code, whatever the strap.

A new code is applied by the divider only at the end of its current period. No enable pulse is ever cut short or doubled.

Top module: `clk_prescale_guard`

## Requirements
- R1: On a clock edge with rst_n low, the select code becomes 3 (divide by 8) if strap_div8 is 1, and 0 (divide by 1) if it is 0. The window is closed and the divider restarts its count.
- R2: rd_data shows the window state in bit 7 (1 = open), zeros in bits 6:4 and the programmed select code in bits 3:0, one cycle after the write edge that changed them.
- R3: A write of exactly 8'h80 opens the unlock window for the next four clock edges. This also holds while the window is already open, in which case the four edges count again from this write.
- R4: A write with bit 7 clear, on any of those four edges, loads a legal code (0 to 8) into the select register and closes the window.
- R5: If none of the four edges after an arming write carries a write, the window closes. A select write made after that leaves the code unchanged.
- R6: A write with bit 7 set and any of bits 6:0 set does not open the window, and it closes an open one. A write with bit 7 clear while the window is closed is ignored.
- R7: A second-step write carrying a reserved code (9 to 15) leaves the select code unchanged and closes the window.
- R8: With active code k, clk_en is high for exactly one cycle in every 2^k cycles. For k = 0 it is high on every cycle.
- R9: A new code takes effect only after the current enable period ends. That period keeps the old length, and the next one has the new length.
- R10: The strap only sets the reset value. When the strap is active, writing code 0 through the unlock sequence gives divide-by-1 operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_div8 | input | 1 | Reset-default strap: 1 selects divide-by-8 after reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data: bit 7 change-enable, bits 3:0 select code |
| rd_data | output | 8 | Register read data: bit 7 window open, bits 3:0 programmed code |
| clk_en | output | 1 | Divided clock-enable pulse |

## Verification
- **Register writes.** A write strobed at one rising edge shows up in rd_data during the following cycle. The window bit falls during the cycle after the fourth idle edge.
- **Divider.** clk_en is high in the cycle in which the count reaches its terminal value. A new code changes the pulse spacing only after the next pulse.
- **Reference model.** The bench drives all inputs on the falling edge. It advances a behavioural model at the rising edge from the same inputs. It compares rd_data and clk_en on every falling edge, so each result is sampled half a cycle after the edge that produced it.
- **Directed cases.** On top of the per-cycle comparison, the bench checks:
  - the last legal window edge and the first edge after the window closes;
  - re-arming while the window is open;
  - reserved codes;
  - pulse spacing measured across a code change.

// File: rtl/clk_prescale_pkg.sv
// Package: shared constants of the guarded clock prescaler.
// Assumes: a byte-wide register, change-enable in the top bit, select code in the low nibble.
package clk_prescale_pkg;
    localparam int DATA_W     = 8;   // register width
    localparam int SEL_W      = 4;   // select code width
    localparam int CE_BIT     = 7;   // change-enable bit position
    localparam int MAX_CODE   = 8;   // highest legal code (divide by 2**MAX_CODE)
    localparam int WIN_CYC    = 4;   // edges during which the second step is accepted
    localparam int STRAP_CODE = 3;   // reset code when the strap is active
endpackage

// File: rtl/clk_prescale_unlock.sv
// Module: unlock window tracker.
// Opens a window of WIN_CYC edges after an exact arming write and flags the
// second-step write that falls inside it.
// Assumes: wr_data is stable around the edge that samples wr_en.
module clk_prescale_unlock #(
    parameter int DATA_W  = clk_prescale_pkg::DATA_W,
    parameter int CE_BIT  = clk_prescale_pkg::CE_BIT,
    parameter int WIN_CYC = clk_prescale_pkg::WIN_CYC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              win_open,
    output logic              step2
);
    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam logic [DATA_W-1:0] ARM_PAT = DATA_W'(1) << CE_BIT;

    logic [WIN_W-1:0] win_cnt;
    logic             arm;

    // Decode the arming write: change-enable set, all other bits clear.
    assign arm      = wr_en && (wr_data == ARM_PAT);
    assign win_open = (win_cnt != '0);
    assign step2    = wr_en && win_open && !wr_data[CE_BIT];

    // Window counter: reload on arm, drop on any other write, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (arm) begin
            win_cnt <= WIN_W'(WIN_CYC);
        end else if (wr_en && win_open) begin
            win_cnt <= '0;
        end else if (win_open) begin
            win_cnt <= win_cnt - 1'b1;
        end
    end

    AST_WIN_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> win_open); // R3
    AST_WIN_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt == WIN_W'(1) && !wr_en) |=> !win_open); // R5
    AST_WIN_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        step2 |=> !win_open); // R4
    AST_NO_ARM_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CE_BIT] && !arm) |=> !win_open); // R6
endmodule

// File: rtl/clk_prescale_sel.sv
// Module: programmed select register.
// Loads a new code on an accepted second-step write when the code is legal;
// reserved codes are dropped.
// Assumes: rst_code is itself a legal code.
module clk_prescale_sel #(
    parameter int SEL_W    = clk_prescale_pkg::SEL_W,
    parameter int MAX_CODE = clk_prescale_pkg::MAX_CODE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rst_code,
    input  logic             step2,
    input  logic [SEL_W-1:0] wr_code,
    output logic [SEL_W-1:0] sel
);
    logic legal;

    // Legal-code filter.
    assign legal = (wr_code <= SEL_W'(MAX_CODE));

    // Select register: reset to the strap code, load legal second-step codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= rst_code;
        end else if (step2 && legal) begin
            sel <= wr_code;
        end
    end

    AST_SEL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        !step2 |=> $stable(sel)); // R6
    AST_RSV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (step2 && !legal) |=> $stable(sel)); // R7
    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step2 && legal) |=> (sel == $past(wr_code))); // R4
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        sel <= SEL_W'(MAX_CODE)); // R7
endmodule

// File: rtl/clk_prescale_div.sv
// Module: divider counter.
// Counts up to 2**act-1, pulses clk_en on the terminal count and only then
// takes the programmed code as the new active code.
// Assumes: sel never holds a code above MAX_CODE.
module clk_prescale_div #(
    parameter int SEL_W    = clk_prescale_pkg::SEL_W,
    parameter int MAX_CODE = clk_prescale_pkg::MAX_CODE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rst_code,
    input  logic [SEL_W-1:0] sel,
    output logic             clk_en
);
    localparam int CNT_W = (MAX_CODE < 1) ? 1 : MAX_CODE;

    logic [CNT_W-1:0]  cnt;
    logic [SEL_W-1:0]  act;
    logic [MAX_CODE:0] hit;
    logic              terminal;

    // One terminal-count comparator per legal code.
    for (genvar gi = 0; gi <= MAX_CODE; gi++) begin : g_hit
        assign hit[gi] = (cnt == CNT_W'((1 << gi) - 1));
    end

    // Pick the comparator of the active code.
    always_comb begin
        terminal = 1'b0;
        for (int i = 0; i <= MAX_CODE; i++) begin
            if (act == SEL_W'(i)) terminal = hit[i];
        end
    end

    assign clk_en = terminal;

    // Counter and active code: wrap and reload the code only at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            act <= rst_code;
        end else if (terminal) begin
            cnt <= '0;
            act <= sel;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_DIV1_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> clk_en); // R8
    AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && sel != '0) |=> !clk_en); // R8
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(act)); // R9
endmodule

// File: rtl/clk_prescale_guard.sv
// Module: guarded clock prescaler top.
// Ties the unlock window, select register and divider together and builds
// the read-back word.
// Assumes: CE_BIT lies above the select field inside DATA_W.
module clk_prescale_guard #(
    parameter int DATA_W     = clk_prescale_pkg::DATA_W,
    parameter int SEL_W      = clk_prescale_pkg::SEL_W,
    parameter int CE_BIT     = clk_prescale_pkg::CE_BIT,
    parameter int MAX_CODE   = clk_prescale_pkg::MAX_CODE,
    parameter int WIN_CYC    = clk_prescale_pkg::WIN_CYC,
    parameter int STRAP_CODE = clk_prescale_pkg::STRAP_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_div8,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              clk_en
);
    logic             win_open;
    logic             step2;
    logic [SEL_W-1:0] sel;
    logic [SEL_W-1:0] rst_code;

    // Reset code chosen by the strap.
    assign rst_code = strap_div8 ? SEL_W'(STRAP_CODE) : '0;

    clk_prescale_unlock #(
        .DATA_W (DATA_W),
        .CE_BIT (CE_BIT),
        .WIN_CYC(WIN_CYC)
    ) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .win_open(win_open),
        .step2   (step2)
    );

    clk_prescale_sel #(
        .SEL_W   (SEL_W),
        .MAX_CODE(MAX_CODE)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_code(rst_code),
        .step2   (step2),
        .wr_code (wr_data[SEL_W-1:0]),
        .sel     (sel)
    );

    clk_prescale_div #(
        .SEL_W   (SEL_W),
        .MAX_CODE(MAX_CODE)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_code(rst_code),
        .sel     (sel),
        .clk_en  (clk_en)
    );

    // Read-back word: window flag, zero padding, programmed code.
    always_comb begin
        rd_data              = '0;
        rd_data[SEL_W-1:0]   = sel;
        rd_data[CE_BIT]      = win_open;
    end

    AST_RST_CODE: assert property (@(posedge clk)
        !rst_n |=> (sel == $past(rst_code) && !win_open)); // R1
endmodule

// File: tb/clk_prescale_guard_tb.sv
`timescale 1ns/1ps
module clk_prescale_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_div8 = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       clk_en;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    clk_prescale_guard u_dut (
        .clk(clk), .rst_n(rst_n), .strap_div8(strap_div8),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .clk_en(clk_en)
    );

    // Behavioural reference model.
    int m_sel, m_act, m_cnt, m_win;
    bit m_valid = 1'b0;

    always @(posedge clk) begin
        int old_sel;
        bit term;
        old_sel = m_sel;
        if (!rst_n) begin
            m_sel = strap_div8 ? 3 : 0;
            m_act = m_sel;
            m_cnt = 0;
            m_win = 0;
            m_valid = 1'b1;
        end else if (m_valid) begin
            term = (m_cnt == (1 << m_act) - 1);
            if (wr_en) begin
                if (wr_data == 8'h80) m_win = 4;
                else if (m_win > 0) begin
                    if (!wr_data[7] && wr_data[3:0] <= 8) m_sel = wr_data[3:0];
                    m_win = 0;
                end
            end else if (m_win > 0) begin
                m_win = m_win - 1;
            end
            if (term) begin
                m_cnt = 0;
                m_act = old_sel;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (m_valid && rst_n) begin
            chk(rd_data == {(m_win > 0), 3'b000, 4'(m_sel)}, "R2 readback", rd_data,
                {(m_win > 0), 3'b000, 4'(m_sel)});
            chk(clk_en == (m_cnt == (1 << m_act) - 1), "R8 clk_en", clk_en,
                (m_cnt == (1 << m_act) - 1));
        end
    end

    task automatic write_reg(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock_write(input logic [7:0] code);
        write_reg(8'h80);
        write_reg(code);
    endtask

    task automatic next_gap(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!clk_en);
    endtask

    initial begin
        int g;
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        chk(rd_data == 8'h03, "R1 strap on reset", rd_data, 8'h03);
        idle(20);

        // R10: strap active, write divide-by-1.
        write_reg(8'h80);
        chk(rd_data == 8'h83, "R3 window open", rd_data, 8'h83);
        write_reg(8'h00);
        chk(rd_data == 8'h00, "R10 code 0 under strap", rd_data, 8'h00);
        idle(10);
        for (int i = 0; i < 3; i++) begin
            chk(clk_en == 1'b1, "R10 divide by 1", clk_en, 1);
            @(negedge clk);
        end

        // R4: last legal edge of the window.
        write_reg(8'h80);
        idle(3);
        chk(rd_data[7] == 1'b1, "R5 window still open", rd_data[7], 1);
        write_reg(8'h05);
        chk(rd_data == 8'h05, "R4 fourth edge accepted", rd_data, 8'h05);

        // R5: expiry.
        write_reg(8'h80);
        idle(4);
        chk(rd_data == 8'h05, "R5 window expired", rd_data, 8'h05);
        write_reg(8'h02);
        chk(rd_data == 8'h05, "R5 late write ignored", rd_data, 8'h05);

        // R6: dirty arming and write while closed.
        write_reg(8'h81);
        chk(rd_data[7] == 1'b0, "R6 dirty arm", rd_data[7], 0);
        write_reg(8'h02);
        chk(rd_data == 8'h05, "R6 closed write ignored", rd_data, 8'h05);
        write_reg(8'h80);
        write_reg(8'hC0);
        chk(rd_data == 8'h05, "R6 dirty write closes", rd_data, 8'h05);
        write_reg(8'h02);
        chk(rd_data == 8'h05, "R6 after close", rd_data, 8'h05);

        // R3: re-arm restarts the window.
        write_reg(8'h80);
        idle(2);
        write_reg(8'h80);
        idle(3);
        write_reg(8'h06);
        chk(rd_data == 8'h06, "R3 re-arm restart", rd_data, 8'h06);

        // R7: reserved codes.
        unlock_write(8'h0B);
        chk(rd_data == 8'h06, "R7 reserved 0xB", rd_data, 8'h06);
        unlock_write(8'h0F);
        chk(rd_data == 8'h06, "R7 reserved 0xF", rd_data, 8'h06);
        unlock_write(8'h09);
        chk(rd_data == 8'h06, "R7 reserved 0x9", rd_data, 8'h06);
        unlock_write(8'h08);
        chk(rd_data == 8'h08, "R4 code 8", rd_data, 8'h08);

        // R8: spacing for code 2.
        idle(300);
        unlock_write(8'h02);
        idle(300);
        while (!clk_en) @(negedge clk);
        next_gap(g);
        chk(g == 4, "R8 period code 2", g, 4);
        next_gap(g);
        chk(g == 4, "R8 period code 2 again", g, 4);

        // R9: change from code 3 to 1 in mid-period.
        unlock_write(8'h03);
        idle(20);
        while (!clk_en) @(negedge clk);
        unlock_write(8'h01);
        g = 2;
        while (!clk_en) begin
            @(negedge clk);
            g++;
        end
        g = g;
        chk(g == 8, "R9 old period kept", g, 8);
        next_gap(g);
        chk(g == 2, "R9 new period", g, 2);

        // R1: reset with strap inactive.
        strap_div8 = 1'b0;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        chk(rd_data == 8'h00, "R1 no strap", rd_data, 8'h00);
        chk(clk_en == 1'b1, "R1 divide by 1 after reset", clk_en, 1);
        idle(10);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule